// File: doc/BRIEF.md
# Set-Associative Cache Statistics Tracker

This block keeps the bookkeeping of a one-level cache that sits between a processor's load/store port and memory. It holds no data. For each access it keeps only the valid bits, the tags and the exact recency order of the ways. Each request carries a 32-bit byte address and a read/write flag. The block splits the address and searches the selected set. It reports hit or miss and the way it used. It then installs the block on a miss and refreshes the recency order. Four saturating counters record what the access stream did.

The associativity and the total block count are parameters. Direct-mapped (one way), set-associative and fully associative (ways equal to blocks, one set, no index bits) configurations all come from the same source. Writes allocate like reads. A write is counted only in the write counter, never in the hit or miss statistics.

Top module: `cache_stat_tracker`

## Requirements
- R1: `req_ready` is 1 once reset is released. A request accepted at a clock edge (`req_valid` and `req_ready` both 1) gives `rsp_valid` = 1 in the following cycle. `rsp_valid` is 0 in every cycle that does not follow an accepted request. Back-to-back requests are accepted every cycle.
- R2: A block is 16 bytes, so address bits [3:0] are the byte offset and do not affect the lookup. The next log2(NUM_BLOCKS/NUM_WAYS) bits are the set index, and every remaining upper bit is the tag. Two addresses that differ only in bits [3:0] refer to the same block.
- R3: Reset clears every valid bit and sets all four counters to 0, so the first access to any set after reset is a miss.
- R4: An access hits when a valid way of the selected set holds the request's tag. `rsp_hit` is then 1 and `rsp_way` gives that way's number.
- R5: On a miss in a set that still has invalid ways, the lowest-numbered invalid way is filled and reported in `rsp_way`. No valid way is evicted while an invalid way exists.
- R6: On a miss in a full set, the way whose last access is the oldest of the set is replaced. This is exact least-recently-used order over all earlier reads and writes.
- R7: A write miss installs the tag like a read miss. Every write, hit or miss, makes its way the most recently used in its set.
- R8: `cnt_reads` counts accepted reads and `cnt_writes` counts accepted writes. `cnt_read_hits` and `cnt_read_misses` count the outcome of reads only, and writes never change them.
- R9: Each counter stops at its all-ones value (2^CNT_W - 1) and never wraps.
- R10: Sets are independent. An access changes neither the contents nor the recency order of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| rsp_hit | output | 1 | 1 when the access hit |
| rsp_way | output | WAY_W | Way that was hit or filled |
| cnt_reads | output | CNT_W | Accepted read accesses |
| cnt_writes | output | CNT_W | Accepted write accesses |
| cnt_read_hits | output | CNT_W | Reads that hit |
| cnt_read_misses | output | CNT_W | Reads that missed |

## Verification
A corrupted recency order does not show on the next response. It appears only at the next miss in a full set of that set, where `rsp_way` names the wrong victim. A later access to the evicted block then hits or misses wrongly, possibly many accesses afterwards. For this reason the bench follows every access with an independent timestamp-based model and compares hit and way on each response. A bad tag or valid bit shows up at the next access to that block as a wrong `rsp_hit`. A misclassified access shows in the counters one cycle after acceptance.

// File: rtl/cst_pkg.sv
package cst_pkg;

    // four 32-bit words per block
    localparam int BLOCK_WORDS = 4;
    localparam int WORD_BYTES  = 4;
    localparam int OFFSET_W    = $clog2(BLOCK_WORDS * WORD_BYTES);

    // width of an index over n items, at least one bit
    function automatic int width_of(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

endpackage

// File: rtl/cst_addr_split.sv
module cst_addr_split
    import cst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2,
    parameter int SET_W  = 2,
    parameter int TAG_W  = 26
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);

    logic unused_offset;
    assign unused_offset = ^addr[OFFSET_W-1:0];

    generate
        if (IDX_W == 0) begin : g_single_set
            assign set_idx = '0;
        end else begin : g_indexed
            assign set_idx = addr[OFFSET_W +: IDX_W];
        end
    endgenerate

    assign tag = addr[ADDR_W-1:OFFSET_W+IDX_W];

endmodule

// File: rtl/cst_way_select.sv
module cst_way_select #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 26,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]             row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
    input  logic [WAYS-1:0][WAY_W-1:0]  row_age,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            way,
    output logic [WAYS-1:0][WAY_W-1:0]  new_age
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic             inv_found;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] old_age;

    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        inv_found = 1'b0;
        inv_way   = '0;
        lru_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && row_valid[w] && (row_tag[w] == req_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!inv_found && !row_valid[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
            if (row_age[w] == OLDEST) begin
                lru_way = WAY_W'(w);
            end
        end
        if (hit) begin
            way = hit_way;
        end else if (inv_found) begin
            way = inv_way;
        end else begin
            way = lru_way;
        end
        old_age = row_age[way];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way) begin
                new_age[w] = '0;
            end else if (row_age[w] < old_age) begin
                new_age[w] = row_age[w] + 1'b1;
            end else begin
                new_age[w] = row_age[w];
            end
        end
    end

endmodule

// File: rtl/cst_tag_store.sv
module cst_tag_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 26,
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [SET_W-1:0]            sel_set,
    input  logic [WAY_W-1:0]            upd_way,
    input  logic [TAG_W-1:0]            upd_tag,
    input  logic [WAYS-1:0][WAY_W-1:0]  upd_age,
    output logic [WAYS-1:0]             row_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  row_tag,
    output logic [WAYS-1:0][WAY_W-1:0]  row_age
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age;
    } store_t;

    store_t st_d, st_q;

    assign row_valid = st_q.valid[sel_set];
    assign row_tag   = st_q.tag[sel_set];
    assign row_age   = st_q.age[sel_set];

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.valid[sel_set][upd_way] = 1'b1;
            st_d.tag[sel_set][upd_way]   = upd_tag;
            st_d.age[sel_set]            = upd_age;
        end
    end

    // invalid ways start with ages equal to their index, so the
    // lowest invalid way is always the youngest invalid one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.tag   <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q.age[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R5 / R7: the way that was touched holds the request tag and is valid
    a_r7_entry_installed: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (st_q.valid[$past(sel_set)][$past(upd_way)] &&
                    st_q.tag[$past(sel_set)][$past(upd_way)] == $past(upd_tag)));

    // R6: the touched way becomes the youngest of its set
    a_r6_touched_youngest: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (st_q.age[$past(sel_set)][$past(upd_way)] == '0));

endmodule

// File: rtl/cst_stat_counters.sv
module cst_stat_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_write,
    input  logic             acc_hit,
    output logic [CNT_W-1:0] cnt_reads,
    output logic [CNT_W-1:0] cnt_writes,
    output logic [CNT_W-1:0] cnt_read_hits,
    output logic [CNT_W-1:0] cnt_read_misses
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] reads;
        logic [CNT_W-1:0] writes;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + 1'b1;
    endfunction

    always_comb begin
        cnt_d = cnt_q;
        if (acc_en) begin
            if (acc_write) begin
                cnt_d.writes = bump(cnt_q.writes);
            end else begin
                cnt_d.reads = bump(cnt_q.reads);
                if (acc_hit) begin
                    cnt_d.hits = bump(cnt_q.hits);
                end else begin
                    cnt_d.misses = bump(cnt_q.misses);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_reads       = cnt_q.reads;
    assign cnt_writes      = cnt_q.writes;
    assign cnt_read_hits   = cnt_q.hits;
    assign cnt_read_misses = cnt_q.misses;

    // R8: until reads saturate, every read is either a hit or a miss
    a_r8_read_split: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.reads != CNT_MAX) |->
            ({1'b0, cnt_q.reads} == {1'b0, cnt_q.hits} + {1'b0, cnt_q.misses}));

    // R9: counters never go backwards
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q.writes >= $past(cnt_q.writes) &&
                  cnt_q.reads  >= $past(cnt_q.reads)));

endmodule

// File: rtl/cache_stat_tracker.sv
module cache_stat_tracker
    import cst_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_BLOCKS = 16,
    parameter int NUM_WAYS   = 4,
    parameter int CNT_W      = 32,
    localparam int WAY_W     = width_of(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [CNT_W-1:0]  cnt_reads,
    output logic [CNT_W-1:0]  cnt_writes,
    output logic [CNT_W-1:0]  cnt_read_hits,
    output logic [CNT_W-1:0]  cnt_read_misses
);

    localparam int SETS  = NUM_BLOCKS / NUM_WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int SET_W = width_of(SETS);
    localparam int TAG_W = ADDR_W - OFFSET_W - IDX_W;

    typedef struct packed {
        logic             ready;
        logic             valid;
        logic             hit;
        logic [WAY_W-1:0] way;
    } rsp_t;

    rsp_t r_d, r_q;

    logic                        accept;
    logic [SET_W-1:0]            set_idx;
    logic [TAG_W-1:0]            req_tag;
    logic [NUM_WAYS-1:0]         row_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0] row_tag;
    logic [NUM_WAYS-1:0][WAY_W-1:0] row_age;
    logic [NUM_WAYS-1:0][WAY_W-1:0] new_age;
    logic                        look_hit;
    logic [WAY_W-1:0]            look_way;
    acc_kind_e                   kind;

    assign accept = req_valid && r_q.ready;
    assign kind   = req_write ? ACC_WRITE : ACC_READ;

    cst_addr_split #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .SET_W  (SET_W),
        .TAG_W  (TAG_W)
    ) i_split (
        .addr    (req_addr),
        .set_idx (set_idx),
        .tag     (req_tag)
    );

    cst_tag_store #(
        .SETS  (SETS),
        .WAYS  (NUM_WAYS),
        .TAG_W (TAG_W),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (accept),
        .sel_set   (set_idx),
        .upd_way   (look_way),
        .upd_tag   (req_tag),
        .upd_age   (new_age),
        .row_valid (row_valid),
        .row_tag   (row_tag),
        .row_age   (row_age)
    );

    cst_way_select #(
        .WAYS  (NUM_WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) i_select (
        .row_valid (row_valid),
        .row_tag   (row_tag),
        .row_age   (row_age),
        .req_tag   (req_tag),
        .hit       (look_hit),
        .way       (look_way),
        .new_age   (new_age)
    );

    cst_stat_counters #(
        .CNT_W (CNT_W)
    ) i_counters (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_en          (accept),
        .acc_write       (kind == ACC_WRITE),
        .acc_hit         (look_hit),
        .cnt_reads       (cnt_reads),
        .cnt_writes      (cnt_writes),
        .cnt_read_hits   (cnt_read_hits),
        .cnt_read_misses (cnt_read_misses)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ready = 1'b1;
        r_d.valid = accept;
        if (accept) begin
            r_d.hit = look_hit;
            r_d.way = look_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.ready;
    assign rsp_valid = r_q.valid;
    assign rsp_hit   = r_q.hit;
    assign rsp_way   = r_q.way;

    // R1: each accepted request answers in the next cycle
    a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R1: no response without an accepted request
    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

endmodule

// File: tb/test_cache_stat_tracker.sv
`timescale 1ns/1ps
module test_cache_stat_tracker;

    localparam int BLOCKS = 8;
    localparam int WAYS   = 2;
    localparam int SETS   = BLOCKS / WAYS;
    localparam int IDX_W  = 2;
    localparam int CNT_W  = 6;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [0:0]        rsp_way;
    logic [CNT_W-1:0]  cnt_reads, cnt_writes, cnt_read_hits, cnt_read_misses;

    always #2 clk = ~clk;

    cache_stat_tracker #(
        .ADDR_W     (32),
        .NUM_BLOCKS (BLOCKS),
        .NUM_WAYS   (WAYS),
        .CNT_W      (CNT_W)
    ) i_cache_stat_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .rsp_valid       (rsp_valid),
        .rsp_hit         (rsp_hit),
        .rsp_way         (rsp_way),
        .cnt_reads       (cnt_reads),
        .cnt_writes      (cnt_writes),
        .cnt_read_hits   (cnt_read_hits),
        .cnt_read_misses (cnt_read_misses)
    );

    typedef struct {
        bit    hit;
        int    way;
        string rq;
    } exp_t;

    exp_t sb[$];

    int n_checks = 0;
    int n_fails  = 0;

    // reference model: per-way last-use timestamp, smallest is LRU
    bit          m_valid[SETS][WAYS];
    logic [31:0] m_tag[SETS][WAYS];
    int          m_stamp[SETS][WAYS];
    int          stamp_ctr = 0;
    int          e_reads = 0, e_writes = 0, e_hits = 0, e_misses = 0;

    function automatic int sat_inc(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input string rq);
        int          s;
        logic [31:0] t;
        int          way;
        bit          hit;
        s   = int'((a >> 4) & (SETS - 1));
        t   = a >> (4 + IDX_W);
        way = -1;
        hit = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && m_valid[s][w] && m_tag[s][w] == t) begin
                hit = 1'b1;
                way = w;
            end
        end
        if (!hit) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way < 0 && !m_valid[s][w]) way = w;
            end
            if (way < 0) begin
                way = 0;
                for (int w = 1; w < WAYS; w++) begin
                    if (m_stamp[s][w] < m_stamp[s][way]) way = w;
                end
            end
        end
        stamp_ctr++;
        m_valid[s][way] = 1'b1;
        m_tag[s][way]   = t;
        m_stamp[s][way] = stamp_ctr;
        if (wr) begin
            e_writes = sat_inc(e_writes);
        end else begin
            e_reads = sat_inc(e_reads);
            if (hit) e_hits = sat_inc(e_hits);
            else     e_misses = sat_inc(e_misses);
        end
        @(negedge clk);
        sb.push_back('{hit: hit, way: way, rq: rq});
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    task automatic check_counts(input string rq);
        idle(2);
        check(int'(cnt_reads) == e_reads, rq, "cnt_reads", cnt_reads, e_reads);
        check(int'(cnt_writes) == e_writes, rq, "cnt_writes", cnt_writes, e_writes);
        check(int'(cnt_read_hits) == e_hits, rq, "cnt_read_hits", cnt_read_hits, e_hits);
        check(int'(cnt_read_misses) == e_misses, rq, "cnt_read_misses",
              cnt_read_misses, e_misses);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "response without request", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_hit == e.hit, e.rq, "rsp_hit", rsp_hit, e.hit);
                    check(int'(rsp_way) == e.way, e.rq, "rsp_way", rsp_way, e.way);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 1'b0;
                m_tag[s][w]   = '0;
                m_stamp[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state, R1: ready after reset
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R3", "rsp_valid after reset", rsp_valid, 0);
        check_counts("R3");

        // R3/R5: first fills, R2: offset ignored, R4: hits
        access(1'b0, 32'h0000_0000, "R5");
        access(1'b0, 32'h0000_000C, "R2");
        access(1'b0, 32'h0000_0040, "R5");
        access(1'b0, 32'h0000_0000, "R4");
        // R6: full set evicts the least recently used way
        access(1'b0, 32'h0000_0080, "R6");
        access(1'b0, 32'h0000_0040, "R6");
        access(1'b0, 32'h0000_0085, "R4");
        // R10: other sets are untouched by set 0 traffic
        access(1'b0, 32'h0000_0010, "R10");
        access(1'b0, 32'h0000_0030, "R10");
        access(1'b0, 32'h0000_0040, "R10");
        access(1'b0, 32'h0000_0010, "R10");
        idle(1);
        check_counts("R8");

        // R7: write-allocate and write recency
        access(1'b1, 32'h0000_0020, "R7");
        access(1'b0, 32'h0000_0060, "R7");
        access(1'b1, 32'h0000_0024, "R7");
        access(1'b0, 32'h0000_00A0, "R7");
        access(1'b0, 32'h0000_0028, "R7");
        access(1'b0, 32'h0000_0060, "R7");
        // R8: write misses leave hit/miss counters alone
        access(1'b1, 32'h0000_1000, "R8");
        check_counts("R8");
        access(1'b0, 32'h0000_1004, "R8");
        check_counts("R8");

        // R1: long back-to-back stream with mixed patterns, R9 saturation
        lcg = 32'h1234_5678;
        for (int i = 0; i < 80; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            access(1'b1, {20'h0, lcg[17:8], 2'b00}, "R9");
        end
        for (int i = 0; i < 90; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            access(1'b0, {24'h0, lcg[15:10], 2'b00}, "R6");
        end
        check_counts("R9");
        check(req_ready == 1'b1, "R1", "req_ready stays high", req_ready, 1);

        idle(3);
        check(sb.size() == 0, "R1", "responses missing", sb.size(), 0);
        summary();
        $finish;
    end

endmodule